// File: doc/BRIEF.md
# Real-Time Clock Sub-Second Shift Controller

This block keeps time for a real-time clock: a down-counting prescaler divides a slow tick into seconds, and a seconds counter accumulates them. Software corrects the phase of the clock through one write-only shift register, in a single atomic write. The write can delay the clock by a fraction of a second, or advance it by one second minus a fraction.

The fraction is added to the prescaler's current count at the next prescaler tick, which pushes the next seconds boundary later. An optional add-one-second bit increments the seconds count in the same step. The block raises a pending flag while the correction waits to be applied, and ignores any further shift writes during that time. Writing the fraction clears a synchronised flag. That flag comes back one tick after the correction has been applied.

A tick enable on the single clock stands in for the slow oscillator. The reload value of the prescaler is an input.

Top module: `rtc_shift_ctrl`

## Requirements
- R1: After reset the prescaler count, the seconds count, the pending flag and the synchronised flag are all zero.
- R2: On a tick with no correction pending, a non-zero prescaler count decrements by one. A zero count reloads to the reload value and increments the seconds count by one. Without a tick, count and seconds hold.
- R3: A read of the shift register returns zero in all 32 bits.
- R4: A shift write made while nothing is pending is accepted. The fraction is taken from bits 14:0 and the add-one-second bit from bit 31, and all other bits are ignored. In the next cycle the pending flag is 1 and the synchronised flag is 0.
- R5: A shift write made while the pending flag is 1 has no effect on the correction that is applied or on the flags.
- R6: On the first tick with a correction pending, the prescaler takes count plus fraction instead of decrementing, and the pending flag clears.
- R7: When count plus fraction exceeds the reload value, the prescaler takes the sum minus (reload + 1), and that tick withholds one seconds increment (seconds minus one).
- R8: With the add-one-second bit set, the applying tick increments the seconds count by one. Together with a wrap the net change in seconds is zero.
- R9: A fraction larger than the reload value is treated as equal to the reload value.
- R10: The synchronised flag is set by any tick that sees no pending correction and no accepted write. This includes the first tick after reset and the tick after an applied correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler tick enable |
| reload | input | 15 | Prescaler reload value |
| reg_wr | input | 1 | Shift register write strobe |
| reg_wdata | input | 32 | Shift register write data |
| reg_rd | input | 1 | Shift register read strobe |
| reg_rdata | output | 32 | Shift register read data (always zero) |
| shift_pend | output | 1 | Correction pending flag |
| shadow_sync | output | 1 | Shadow time synchronised flag |
| presc_cnt | output | 15 | Current prescaler count |
| sec_cnt | output | 17 | Seconds count |

## Verification
The bench applies corrections at prescaler counts where the sum stays in range, lands exactly on the reload value, and crosses it. A design that compares with the wrong bound would withhold a second one count early or let the prescaler run past the reload value. It sends a second write while the first is pending, with different fields, and a write in the same cycle as a tick. A design that does not lock out the second write would apply the wrong fraction, and one that applies at once would shift a tick early. It also combines the add-one-second bit with a wrap, uses an oversized fraction, and sets the high noise bits, which would expose a broken clamp, double counting of seconds, or a mis-placed field.

// File: rtl/rtc_shift_pkg.sv
package rtc_shift_pkg;
  localparam int FRAC_W   = 15;
  localparam int REG_W    = 32;
  localparam int ADD1_POS = 31;

  typedef struct packed {
    logic              add1;
    logic [FRAC_W-1:0] frac;
  } shift_req_t;
endpackage

// File: rtl/rtc_shift_wr.sv
module rtc_shift_wr
  import rtc_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic             pend,
  output logic             sync,
  output shift_req_t       req
);
  logic       pend_q, pend_d;
  logic       sync_q, sync_d;
  shift_req_t req_q, req_d;
  logic       accept;
  logic       apply;

  assign accept = wr_en & ~pend_q;
  assign apply  = tick & pend_q;

  always_comb begin
    pend_d = pend_q;
    sync_d = sync_q;
    req_d  = req_q;
    if (apply)
      pend_d = 1'b0;
    if (tick && !pend_q)
      sync_d = 1'b1;
    if (accept) begin
      pend_d     = 1'b1;
      sync_d     = 1'b0;
      req_d.add1 = wdata[ADD1_POS];
      req_d.frac = wdata[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sync_q <= 1'b0;
      req_q  <= '0;
    end else begin
      pend_q <= pend_d;
      sync_q <= sync_d;
      req_q  <= req_d;
    end
  end

  assign pend = pend_q;
  assign sync = sync_q;
  assign req  = req_q;

  // R5: a locked-out write leaves the held request and the flag alone
  assert_locked_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !tick) |=> (pend_q && $stable(req_q)));
  // R6: the applying tick retires the request
  assert_apply_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tick) |=> !pend_q);
  // R10: an idle tick with no accepted write marks the shadow synchronised
  assert_sync_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && !wr_en) |=> sync_q);
endmodule

// File: rtl/rtc_shift_presc.sv
module rtc_shift_presc #(
  parameter int PW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          apply,
  input  logic          add1,
  input  logic [PW-1:0] frac,
  input  logic [PW-1:0] reload,
  output logic [PW-1:0] cnt,
  output logic          sec_inc,
  output logic          sec_dec
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] eff;
  logic [PW:0]   sum;
  logic [PW:0]   wrapped;
  logic          over;

  assign eff     = (frac > reload) ? reload : frac;
  assign sum     = {1'b0, cnt_q} + {1'b0, eff};
  assign over    = sum > {1'b0, reload};
  assign wrapped = sum - {1'b0, reload} - {{PW{1'b0}}, 1'b1};

  always_comb begin
    cnt_d   = cnt_q;
    sec_inc = 1'b0;
    sec_dec = 1'b0;
    if (apply) begin
      sec_inc = add1;
      if (over) begin
        cnt_d   = wrapped[PW-1:0];
        sec_dec = 1'b1;
      end else begin
        cnt_d = sum[PW-1:0];
      end
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_d   = reload;
        sec_inc = 1'b1;
      end else begin
        cnt_d = cnt_q - {{(PW-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2: without a tick the prescaler holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R2: a plain tick on a non-zero count steps down by one
  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !apply && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R7: after a correction the count sits inside the reload range
  assert_apply_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (cnt_q <= $past(reload)));
endmodule

// File: rtl/rtc_shift_sec.sv
module rtc_shift_sec #(
  parameter int SW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [SW-1:0] sec
);
  logic [SW-1:0] sec_q, sec_d;

  always_comb begin
    sec_d = sec_q;
    unique case ({inc, dec})
      2'b10:   sec_d = sec_q + {{(SW-1){1'b0}}, 1'b1};
      2'b01:   sec_d = sec_q - {{(SW-1){1'b0}}, 1'b1};
      default: sec_d = sec_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= '0;
    else        sec_q <= sec_d;
  end

  assign sec = sec_q;

  // R8: an increment and a withheld second cancel
  assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(sec_q));
endmodule

// File: rtl/rtc_shift_ctrl.sv
module rtc_shift_ctrl
  import rtc_shift_pkg::*;
#(
  parameter int SEC_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FRAC_W-1:0] reload,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              shift_pend,
  output logic              shadow_sync,
  output logic [FRAC_W-1:0] presc_cnt,
  output logic [SEC_W-1:0]  sec_cnt
);
  shift_req_t req;
  logic       apply;
  logic       sec_inc;
  logic       sec_dec;
  logic       rd_unused;

  // write-only register: reads never expose the held request
  assign rd_unused = reg_rd;
  assign reg_rdata = '0;

  rtc_shift_wr u_wr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_en (reg_wr),
    .wdata (reg_wdata),
    .pend  (shift_pend),
    .sync  (shadow_sync),
    .req   (req)
  );

  assign apply = tick & shift_pend;

  rtc_shift_presc #(.PW(FRAC_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .apply   (apply),
    .add1    (req.add1),
    .frac    (req.frac),
    .reload  (reload),
    .cnt     (presc_cnt),
    .sec_inc (sec_inc),
    .sec_dec (sec_dec)
  );

  rtc_shift_sec #(.SW(SEC_W)) u_sec (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (sec_inc),
    .dec   (sec_dec),
    .sec   (sec_cnt)
  );

  // R4: an accepted write raises pending and drops the synchronised flag
  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !shift_pend) |=> (shift_pend && !shadow_sync));
  // R2: seconds move only on a tick
  assert_sec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sec_cnt));
endmodule

// File: tb/rtc_shift_ctrl_bench.sv
`timescale 1ns/1ps
module rtc_shift_ctrl_bench;
  localparam int RL = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [14:0] reload = 15'(RL);
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        shift_pend, shadow_sync;
  logic [14:0] presc_cnt;
  logic [16:0] sec_cnt;

  always #5 clk = ~clk;

  rtc_shift_ctrl u_rtc_shift_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .shift_pend(shift_pend),
    .shadow_sync(shadow_sync), .presc_cnt(presc_cnt), .sec_cnt(sec_cnt)
  );

  typedef struct {
    int    cnt;
    int    sec;
    bit    pend;
    bit    sync;
    string req;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int m_cnt = 0, m_sec = 0, m_frac = 0;
  bit m_pend = 0, m_sync = 0, m_add1 = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: drive one cycle and push the expected state after the edge
  task automatic step(bit tk, bit wr, logic [31:0] wd, string req);
    bit acc;
    int eff, sum;
    @(negedge clk);
    tick = tk; reg_wr = wr; reg_wdata = wd;
    acc = wr && !m_pend;
    if (tk && m_pend) begin
      eff = (m_frac > RL) ? RL : m_frac;
      sum = m_cnt + eff;
      if (m_add1) m_sec++;
      if (sum > RL) begin
        m_cnt = sum - RL - 1;
        m_sec--;
      end else m_cnt = sum;
      m_pend = 0;
    end else if (tk) begin
      if (m_cnt == 0) begin m_cnt = RL; m_sec++; end
      else m_cnt--;
      m_sync = 1;
    end
    if (acc) begin
      m_pend = 1; m_sync = 0;
      m_frac = int'(wd[14:0]); m_add1 = wd[31];
    end
    m_sec = m_sec & 32'h1FFFF;
    q.push_back('{m_cnt, m_sec, m_pend, m_sync, req});
  endtask

  task automatic ticks_to(int target, string req);
    while (m_cnt != target) step(1, 0, 32'h0, req);
  endtask

  // monitor: compare one cycle after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(int'(presc_cnt) == e.cnt, e.req, "presc_cnt", int'(presc_cnt), e.cnt);
        chk(int'(sec_cnt) == e.sec, e.req, "sec_cnt", int'(sec_cnt), e.sec);
        chk(shift_pend == e.pend, e.req, "shift_pend", int'(shift_pend), int'(e.pend));
        chk(shadow_sync == e.sync, e.req, "shadow_sync", int'(shadow_sync), int'(e.sync));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(presc_cnt == 0 && sec_cnt == 0, "R1", "counts", int'(presc_cnt) + int'(sec_cnt), 0);
    chk(!shift_pend && !shadow_sync, "R1", "flags", int'(shift_pend) + int'(shadow_sync), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R10: free running, first tick sets sync, several second rollovers
    for (int i = 0; i < 20; i++) step(1, 0, 32'h0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 32'h0, "R2 hold");

    // R3: reads return zero
    @(negedge clk); reg_rd = 1'b1;
    @(posedge clk); #1;
    chk(reg_rdata == 32'h0, "R3", "rdata idle", int'(reg_rdata), 0);

    // R4 / R6: in-range shift, noise bits 30:15 ignored
    ticks_to(2, "R2");
    step(0, 1, 32'h7FFF_8003, "R4");
    @(posedge clk); #1;
    chk(reg_rdata == 32'h0, "R3", "rdata pending", int'(reg_rdata), 0);
    step(0, 0, 32'h0, "R4 wait");
    // R5: a second write while pending must not replace the fraction
    step(0, 1, 32'h8000_0006, "R5");
    step(1, 0, 32'h0, "R6");
    step(1, 0, 32'h0, "R10");
    step(1, 0, 32'h0, "R2");

    // R6 boundary: sum lands exactly on reload
    ticks_to(4, "R2");
    step(0, 1, 32'h0000_0003, "R4");
    step(1, 0, 32'h0, "R6 edge");
    step(1, 0, 32'h0, "R10");

    // R7: sum crosses reload, one second withheld
    ticks_to(5, "R2");
    step(0, 1, 32'h0000_0006, "R4");
    step(1, 0, 32'h0, "R7");
    step(1, 0, 32'h0, "R10");

    // R8: add one second without wrap, then with wrap
    ticks_to(1, "R2");
    step(0, 1, 32'h8000_0002, "R4");
    step(1, 0, 32'h0, "R8");
    ticks_to(6, "R2");
    step(0, 1, 32'h8000_0005, "R4");
    step(1, 0, 32'h0, "R8 wrap");

    // R9: oversized fraction clamps to reload
    ticks_to(3, "R2");
    step(0, 1, 32'h0000_0064, "R4");
    step(1, 0, 32'h0, "R9");

    // write in the same cycle as a tick: apply waits for the next tick
    ticks_to(5, "R2");
    step(1, 1, 32'h0000_0001, "R4 tick");
    step(0, 1, 32'h0000_0005, "R5");
    step(1, 0, 32'h0, "R6");
    for (int i = 0; i < 12; i++) step(1, 0, 32'h0, "R10");

    @(negedge clk); tick = 0; reg_wr = 0; reg_rd = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule